// File: doc/BRIEF.md
# Transmit DMA Channel Control and Status Unit

This block holds the control registers of eight transmit DMA channels, gathers their live status into one readable word and keeps a sticky error word. Each channel owns a 32-bit configuration register. Bits 31:30 select the channel mode: 00 off, 01 stop once the current frame is done, 10 run normally, 11 reserved (treated as off). Bit 3 lets the channel raise internal DMA requests. Registers sit on a simple synchronous write port with combinational read data. Channel c's configuration register is at byte offset c*0x20, the status word is at 0x100 and the error word is at 0x104.

Each channel runs a small state machine with four states. OFF: no activity. RUN: new frames may be fetched. DRAIN: the frame in flight may finish but no new one starts. HALT: stopped after draining. Transitions are taken on the clock edge after the configuration register holds the mode. Mode 10 goes to RUN from any state. Mode 00 or 11 goes to OFF from any state. Mode 01 acts on the idle flag, where a channel is idle when both its buffer-empty and no-pending inputs are high. From RUN or DRAIN, mode 01 goes to DRAIN while the channel is busy and to HALT once it is idle. From OFF or HALT, mode 01 goes to HALT.

The error word captures two per-channel fault kinds and two global host faults. A bit stays set until software writes 1 to its position. The frame data path is outside this block and uses the enable outputs.

Top module: `txdma_ctl_status`

## Requirements
- R1: After reset every configuration register and the error word read 0, all channels are in OFF, and ch_fetch_en, ch_move_en and ch_dreq_en are all 0.
- R2: A write to offset c*0x20 stores bits 31:30 and bit 3 of the write data in channel c's configuration register. A read of that offset returns those bits in the same positions, with every other bit 0.
- R3: A channel is in RUN (ch_fetch_en=1, ch_move_en=1) from the second rising edge after a write of mode 10.
- R4: With mode 01, a busy channel in RUN or DRAIN goes to DRAIN (ch_move_en=1, ch_fetch_en=0). An idle one goes to HALT (both 0), and OFF goes to HALT.
- R5: Mode 00 or 11 puts the channel in OFF on the next edge, whatever its state and activity.
- R6: ch_dreq_en[c] is 1 exactly when channel c's bit 3 is set and the channel is in RUN or DRAIN.
- R7: The word at 0x100 reads buf_empty in bits 31:24 and no_pend in bits 23:16, with other bits 0. ch_idle[c] equals buf_empty[c] AND no_pend[c].
- R8: Error bit c (7:0) is set on the edge after a cycle where fifo_full[c] is 1 and channel c's credit count is nonzero.
- R9: Error bit 9+c (16:9) is set on the edge after a cycle where act_cmd[c] and trb_full[c] are both 1.
- R10: Error bit 31 is set after addr_err_evt and error bit 30 after short_xfer_evt. All other error bits read 0.
- R11: Writing the error word at 0x104 clears the bits written as 1 and leaves the others. An event on a bit in the same cycle as its clear leaves it set.
- R12: Reads of unmapped offsets return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| buf_empty | input | 8 | Per-channel buffers empty |
| no_pend | input | 8 | Per-channel no pending requests |
| fifo_full | input | 8 | Per-channel transmit FIFO full indication |
| credit_cnt | input | 64 | Per-channel 8-bit credit counters, channel c at bits 8c+7:8c |
| act_cmd | input | 8 | Per-channel activate command strobe |
| trb_full | input | 8 | Per-channel request buffer still full |
| addr_err_evt | input | 1 | Internal memory address error strobe |
| short_xfer_evt | input | 1 | Host sent too few dwords strobe |
| ch_fetch_en | output | 8 | Channel may start new frames (RUN) |
| ch_move_en | output | 8 | Channel may move data (RUN or DRAIN) |
| ch_dreq_en | output | 8 | Channel may raise internal DMA requests |
| ch_idle | output | 8 | Channel buffers empty and nothing pending |

## Verification
The hardest path to reach from the ports is DRAIN followed by HALT. It needs mode 01 written while the channel is running and busy, then the channel's idle flags rising while the mode is unchanged. The stimulus reaches it with a directed sequence and also biases the random activity flags so that busy and idle stretches alternate. The other hard case is an error event and its W1C clear in the same cycle. A directed step makes them coincide, and the random phase produces many such overlaps too.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
    localparam int REG_W          = 32;
    localparam int MODE_HI        = 31;
    localparam int MODE_LO        = 30;
    localparam int CRED_EN_BIT    = 3;
    localparam int STAT_EMPTY_LSB = 24;
    localparam int STAT_NOPND_LSB = 16;
    localparam int ERR_ADDR_BIT   = 31;
    localparam int ERR_SHORT_BIT  = 30;
    localparam int ERR_OVR_LSB    = 9;
    localparam int ERR_CRED_LSB   = 0;

    typedef enum logic [1:0] {
        MODE_OFF       = 2'b00,
        MODE_PAUSE_EOF = 2'b01,
        MODE_RUN       = 2'b10,
        MODE_RSVD      = 2'b11
    } ch_mode_e;

    typedef enum logic [1:0] {
        CH_OFF   = 2'b00,
        CH_RUN   = 2'b01,
        CH_DRAIN = 2'b10,
        CH_HALT  = 2'b11
    } ch_state_e;
endpackage

// File: rtl/txdma_chan_ctl.sv
module txdma_chan_ctl
    import txdma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             idle,
    output logic [REG_W-1:0] cfg_rd,
    output logic             fetch_en,
    output logic             move_en,
    output logic             dreq_en
);
    ch_mode_e  mode_q;
    logic      cred_q;
    ch_state_e state_q, state_d;

    // configuration register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            cred_q <= 1'b0;
        end else if (cfg_we) begin
            mode_q <= ch_mode_e'(cfg_wdata[MODE_HI:MODE_LO]);
            cred_q <= cfg_wdata[CRED_EN_BIT];
        end
    end

    always_comb begin
        cfg_rd = '0;
        cfg_rd[MODE_HI:MODE_LO] = mode_q;
        cfg_rd[CRED_EN_BIT]     = cred_q;
    end

    // next-state logic
    always_comb begin
        state_d = CH_OFF;
        unique case (mode_q)
            MODE_RUN: state_d = CH_RUN;
            MODE_PAUSE_EOF: begin
                unique case (state_q)
                    CH_RUN, CH_DRAIN: state_d = idle ? CH_HALT : CH_DRAIN;
                    CH_OFF, CH_HALT:  state_d = CH_HALT;
                endcase
            end
            MODE_OFF, MODE_RSVD: state_d = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        fetch_en = 1'b0;
        move_en  = 1'b0;
        unique case (state_q)
            CH_RUN:   begin fetch_en = 1'b1; move_en = 1'b1; end
            CH_DRAIN: move_en = 1'b1;
            CH_OFF, CH_HALT: ;
        endcase
        dreq_en = move_en & cred_q;
    end
endmodule

// File: rtl/txdma_err_latch.sv
module txdma_err_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_ev,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] err_q
);
    logic [W-1:0] clr_eff;

    always_comb clr_eff = clr_we ? clr_mask : '0;

    // an event beats a clear of the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~clr_eff) | set_ev;
    end
endmodule

// File: rtl/txdma_ctl_status.sv
module txdma_ctl_status
    import txdma_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int CW         = 8,
    parameter int ADDR_W     = 9,
    parameter int CFG_STRIDE = 32,
    parameter int STAT_OFFS  = 256,
    parameter int ERR_OFFS   = 260
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NCH-1:0]    buf_empty,
    input  logic [NCH-1:0]    no_pend,
    input  logic [NCH-1:0]    fifo_full,
    input  logic [NCH*CW-1:0] credit_cnt,
    input  logic [NCH-1:0]    act_cmd,
    input  logic [NCH-1:0]    trb_full,
    input  logic              addr_err_evt,
    input  logic              short_xfer_evt,
    output logic [NCH-1:0]    ch_fetch_en,
    output logic [NCH-1:0]    ch_move_en,
    output logic [NCH-1:0]    ch_dreq_en,
    output logic [NCH-1:0]    ch_idle
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFFS);
    localparam logic [ADDR_W-1:0] ERR_A  = ADDR_W'(ERR_OFFS);

    logic [REG_W-1:0] cfg_rd [NCH];
    logic [NCH-1:0]   cfg_we;
    logic [REG_W-1:0] err_ev;
    logic [REG_W-1:0] err_word;
    logic [REG_W-1:0] stat_word;

    assign ch_idle = buf_empty & no_pend;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign cfg_we[c] = reg_wr && (reg_addr == ADDR_W'(c * CFG_STRIDE));

        txdma_chan_ctl u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we[c]),
            .cfg_wdata(reg_wdata),
            .idle     (ch_idle[c]),
            .cfg_rd   (cfg_rd[c]),
            .fetch_en (ch_fetch_en[c]),
            .move_en  (ch_move_en[c]),
            .dreq_en  (ch_dreq_en[c])
        );
    end

    // error events
    always_comb begin
        err_ev = '0;
        for (int c = 0; c < NCH; c++) begin
            err_ev[ERR_CRED_LSB + c] = fifo_full[c] && (credit_cnt[c*CW +: CW] != '0);
            err_ev[ERR_OVR_LSB + c]  = act_cmd[c] && trb_full[c];
        end
        err_ev[ERR_ADDR_BIT]  = addr_err_evt;
        err_ev[ERR_SHORT_BIT] = short_xfer_evt;
    end

    txdma_err_latch #(.W(REG_W)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (err_ev),
        .clr_we  (reg_wr && (reg_addr == ERR_A)),
        .clr_mask(reg_wdata),
        .err_q   (err_word)
    );

    always_comb begin
        stat_word = '0;
        stat_word[STAT_EMPTY_LSB +: NCH] = buf_empty;
        stat_word[STAT_NOPND_LSB +: NCH] = no_pend;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == STAT_A) reg_rdata = stat_word;
        if (reg_addr == ERR_A)  reg_rdata = err_word;
        for (int c = 0; c < NCH; c++)
            if (reg_addr == ADDR_W'(c * CFG_STRIDE)) reg_rdata = cfg_rd[c];
    end
endmodule

// File: rtl/txdma_ctl_status_chk.sv
module txdma_ctl_status_chk #(
    parameter int NCH    = 8,
    parameter int CW     = 8,
    parameter int ADDR_W = 9,
    parameter int ERR_OFFS = 260
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       err_word,
    input logic [NCH-1:0]    buf_empty,
    input logic [NCH-1:0]    no_pend,
    input logic [NCH-1:0]    fifo_full,
    input logic [NCH*CW-1:0] credit_cnt,
    input logic [NCH-1:0]    act_cmd,
    input logic [NCH-1:0]    trb_full,
    input logic              addr_err_evt,
    input logic              short_xfer_evt,
    input logic [NCH-1:0]    ch_fetch_en,
    input logic [NCH-1:0]    ch_move_en,
    input logic [NCH-1:0]    ch_dreq_en
);
    logic err_clr;
    assign err_clr = reg_wr && (reg_addr == ADDR_W'(ERR_OFFS));

    for (genvar c = 0; c < NCH; c++) begin : g_a
        p_credit_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (fifo_full[c] && (credit_cnt[c*CW +: CW] != '0)) |=> err_word[c]);
        p_overrun_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (act_cmd[c] && trb_full[c]) |=> err_word[9 + c]);
        p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (err_word[c] && !(err_clr && reg_wdata[c])) |=> err_word[c]);
        p_drain_leaves_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_move_en[c] && !ch_fetch_en[c] && buf_empty[c] && no_pend[c])
            |=> !(ch_move_en[c] && !ch_fetch_en[c]));
        p_dreq_needs_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ch_dreq_en[c] |-> ch_move_en[c]);
    end

    p_addr_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_evt |=> err_word[31]);
    p_short_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        short_xfer_evt |=> err_word[30]);
endmodule

bind txdma_ctl_status txdma_ctl_status_chk #(
    .NCH(NCH), .CW(CW), .ADDR_W(ADDR_W), .ERR_OFFS(ERR_OFFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .err_word(err_word), .buf_empty(buf_empty),
    .no_pend(no_pend), .fifo_full(fifo_full), .credit_cnt(credit_cnt),
    .act_cmd(act_cmd), .trb_full(trb_full), .addr_err_evt(addr_err_evt),
    .short_xfer_evt(short_xfer_evt), .ch_fetch_en(ch_fetch_en),
    .ch_move_en(ch_move_en), .ch_dreq_en(ch_dreq_en)
);

// File: tb/sim_txdma_ctl_status.sv
module sim_txdma_ctl_status;
    localparam int NCH = 8;
    localparam int CW  = 8;
    localparam logic [8:0] A_STAT = 9'h100;
    localparam logic [8:0] A_ERR  = 9'h104;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             s_wr = 1'b0;
    logic [8:0]       s_addr = '0;
    logic [31:0]      s_wdata = '0;
    logic [NCH-1:0]   s_be = '0, s_np = '0, s_ff = '0, s_act = '0, s_trb = '0;
    logic [NCH*CW-1:0] s_cred = '0;
    logic             s_aerr = 1'b0, s_serr = 1'b0;
    logic [31:0]      rdata;
    logic [NCH-1:0]   fetch, move, dreq, idle;

    txdma_ctl_status u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(s_wr), .reg_addr(s_addr),
        .reg_wdata(s_wdata), .reg_rdata(rdata), .buf_empty(s_be),
        .no_pend(s_np), .fifo_full(s_ff), .credit_cnt(s_cred),
        .act_cmd(s_act), .trb_full(s_trb), .addr_err_evt(s_aerr),
        .short_xfer_evt(s_serr), .ch_fetch_en(fetch), .ch_move_en(move),
        .ch_dreq_en(dreq), .ch_idle(idle)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model: state 0 off, 1 run, 2 drain, 3 halt
    logic [1:0] m_mode [NCH];
    logic       m_cred [NCH];
    int         m_st   [NCH];
    logic [31:0] m_err;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int nxt_st(input logic [1:0] md, input int st, input logic idl);
        if (md == 2'b10) return 1;
        if (md == 2'b01) begin
            if (st == 1 || st == 2) return idl ? 3 : 2;
            return 3;
        end
        return 0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [8:0] a);
        logic [31:0] r = '0;
        for (int c = 0; c < NCH; c++)
            if (a == 9'(c * 32)) begin
                r[31:30] = m_mode[c];
                r[3]     = m_cred[c];
            end
        if (a == A_STAT) begin
            r[31:24] = s_be;
            r[23:16] = s_np;
        end
        if (a == A_ERR) r = m_err;
        return r;
    endfunction

    function automatic string read_tag(input logic [8:0] a);
        if (a < 9'h100 && a[4:0] == 5'd0) return "R2 read cfg";
        if (a == A_STAT) return "R7 status word";
        if (a == A_ERR)  return "R8 R9 R10 R11 error word";
        return "R12 unmapped read";
    endfunction

    function automatic logic [31:0] exp_ev();
        logic [31:0] e = '0;
        for (int c = 0; c < NCH; c++) begin
            e[c]     = s_ff[c] && (s_cred[c*CW +: CW] != '0);
            e[9 + c] = s_act[c] && s_trb[c];
        end
        e[31] = s_aerr;
        e[30] = s_serr;
        return e;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_mode[c] = 2'b00; m_cred[c] = 1'b0; m_st[c] = 0;
        end
        m_err = '0;
    endtask

    // one cycle: called at a negedge with stimulus set
    task automatic tick();
        logic [NCH-1:0] ef, em, ed;
        int ns [NCH];
        #1;
        for (int c = 0; c < NCH; c++) begin
            ef[c] = (m_st[c] == 1);
            em[c] = (m_st[c] == 1 || m_st[c] == 2);
            ed[c] = em[c] && m_cred[c];
        end
        chk(32'(fetch), 32'(ef), "R3 fetch enable");
        chk(32'(move),  32'(em), "R4 move enable");
        chk(32'(dreq),  32'(ed), "R6 request enable");
        chk(32'(idle),  32'(s_be & s_np), "R7 idle");
        chk(rdata, exp_read(s_addr), read_tag(s_addr));
        for (int c = 0; c < NCH; c++) ns[c] = nxt_st(m_mode[c], m_st[c], s_be[c] & s_np[c]);
        @(posedge clk);
        for (int c = 0; c < NCH; c++) begin
            m_st[c] = ns[c];
            if (s_wr && s_addr == 9'(c * 32)) begin
                m_mode[c] = s_wdata[31:30];
                m_cred[c] = s_wdata[3];
            end
        end
        m_err = (m_err & ~((s_wr && s_addr == A_ERR) ? s_wdata : 32'h0)) | exp_ev();
        @(negedge clk);
    endtask

    task automatic quiet();
        s_wr = 0; s_ff = '0; s_act = '0; s_trb = '0; s_aerr = 0; s_serr = 0; s_cred = '0;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        s_wr = 1; s_addr = a; s_wdata = d;
        tick();
        s_wr = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int c = 0; c < NCH; c++) begin
            s_addr = 9'(c * 32);
            #1 chk(rdata, 32'h0, "R1 cfg after reset");
        end
        s_addr = A_ERR;
        #1 chk(rdata, 32'h0, "R1 error word after reset");
        chk(32'({fetch, move, dreq}), 32'h0, "R1 enables after reset");
        tick();

        // R3 / R6: channel 2 to run with requests
        s_be = '0; s_np = '0;
        wr(9'h040, 32'h8000_0008);
        tick();
        chk(32'(fetch[2]), 32'd1, "R3 run after mode 10");
        chk(32'(dreq[2]),  32'd1, "R6 dreq in run");

        // R4: pause at end of frame while busy, then idle
        wr(9'h040, 32'h4000_0008);
        tick();
        chk(32'({fetch[2], move[2]}), 32'b01, "R4 drain while busy");
        s_be[2] = 1; s_np[2] = 1;
        tick();
        tick();
        chk(32'(move[2]), 32'd0, "R4 halt once idle");

        // R5: reserved mode forces off
        wr(9'h040, 32'h8000_0000);
        tick();
        wr(9'h040, 32'hC000_0000);
        tick();
        chk(32'(move[2]), 32'd0, "R5 mode 11 is off");

        // R11: event and clear on the same bit
        s_ff[0] = 1; s_cred[7:0] = 8'd5;
        tick();
        s_wr = 1; s_addr = A_ERR; s_wdata = 32'h1;
        tick();
        quiet();
        s_addr = A_ERR;
        #1 chk(rdata & 32'h1, 32'h1, "R11 set wins over clear");
        wr(A_ERR, 32'h1);
        s_addr = A_ERR;
        #1 chk(rdata & 32'h1, 32'h0, "R11 clear by write one");

        // R12: unmapped write leaves channel 7
        wr(9'h0E0, 32'h8000_0008);
        wr(9'h0E4, 32'h4000_0000);
        wr(9'h1F0, 32'hFFFF_FFFF);
        s_addr = 9'h0E0;
        #1 chk(rdata, 32'h8000_0008, "R12 unmapped write ignored");
        s_addr = 9'h0E4;
        #1 chk(rdata, 32'h0, "R12 unmapped read zero");
        tick();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int k;
            s_wr = ($urandom_range(0, 9) < 3);
            k = $urandom_range(0, 11);
            if (k < 8)       s_addr = 9'(k * 32);
            else if (k == 8) s_addr = A_STAT;
            else if (k == 9) s_addr = A_ERR;
            else             s_addr = 9'($urandom_range(0, 511));
            s_wdata = $urandom();
            if (s_addr == A_ERR && $urandom_range(0, 1) == 0) s_wdata = s_wdata & $urandom();
            if ($urandom_range(0, 3) == 0) begin
                for (int c = 0; c < NCH; c++) begin
                    s_be[c] = ($urandom_range(0, 9) < 6);
                    s_np[c] = ($urandom_range(0, 9) < 6);
                end
            end
            for (int c = 0; c < NCH; c++) begin
                s_ff[c]  = ($urandom_range(0, 7) == 0);
                s_act[c] = ($urandom_range(0, 7) == 0);
                s_trb[c] = $urandom_range(0, 1);
                s_cred[c*CW +: CW] = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom());
            end
            s_aerr = ($urandom_range(0, 31) == 0);
            s_serr = ($urandom_range(0, 31) == 0);
            tick();
        end

        quiet();
        tick();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule